// File: doc/BRIEF.md
# T1 Transmit System-Side Serial Capture Port

This block sits on the system side of a T1 transmit path when the framer supplies the timing. A 1.544 MHz line clock comes in, oversampled by a faster system clock. The block drives a frame pulse that tells the system where each 193-bit frame begins. It takes one serial data bit per line-clock period and turns the stream into channel bytes. It also pulls out the framing bit on its own.

Each frame starts with one framing bit. Twenty-four channels of eight bits follow it, and the first bit of each channel arrives first on the wire. When a channel's eighth bit has been taken, the block presents the byte with its channel number and a one-cycle strobe. The framing bit value gets its own strobe. Two static configuration inputs set the active edges. One picks the line-clock edge on which data is sampled. The other picks the edge on which the frame pulse changes. All four combinations work.

Top module: `t1tx_sys_port`

## Requirements
- R1: While `rst` is high, and after it falls until the first selected line-clock edge, `frame_pulse`, `byte_valid` and `fbit_valid` are 0. The first bit sampled after reset is a framing bit.
- R2: Exactly one bit of `ser_data` is sampled per line-clock period. With `smp_fall`=1 it is sampled on the falling edge of `line_clk`, and with `smp_fall`=0 on the rising edge.
- R3: `frame_pulse` changes only on the edge selected by `pulse_rise`: the rising edge of `line_clk` when it is 1, the falling edge when it is 0.
- R4: At each pulse-update edge, `frame_pulse` becomes 1 exactly when the next bit still to be sampled is a framing bit, and 0 otherwise. It is therefore high for one line-clock period in every 193 and low for the other 192.
- R5: The sampled bit sequence repeats every 193 bits: a framing bit, then channels 1 to 24 with 8 bits each, and after channel 24 comes the next framing bit.
- R6: After the eighth bit of a channel is sampled, `byte_valid` is high for one system clock. `byte_data` then holds the channel, with its first serial bit in bit 7 and its last in bit 0, and `byte_chan` holds the channel number from 1 to 24.
- R7: After each framing bit is sampled, `fbit_valid` is high for one system clock and `fbit_val` holds the sampled value. This happens once per frame, and never in the same cycle as `byte_valid`.
- R8: Each output reacts to a `line_clk` transition on the third rising edge of `clk` after that transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the line clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clk | input | 1 | 1.544 MHz line clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial transmit data from the system |
| smp_fall | input | 1 | 1: sample data on the falling edge; 0: on the rising edge |
| pulse_rise | input | 1 | 1: update the frame pulse on the rising edge; 0: on the falling edge |
| frame_pulse | output | 1 | Framing-slot marker driven to the system |
| byte_data | output | 8 | Assembled channel byte, first bit in the MSB |
| byte_chan | output | 5 | Channel number 1 to 24 of `byte_data` |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` and `byte_chan` |
| fbit_val | output | 1 | Sampled framing bit value |
| fbit_valid | output | 1 | One-cycle strobe for `fbit_val` |

## Verification
The assertions take for granted that `line_clk` holds each level for at least three system clocks. Under that assumption a rising and a falling edge are never seen in the same cycle, and two sampling edges are never closer than two cycles. They also assume that `smp_fall` and `pulse_rise` change only while `rst` is high. The stimulus holds each line-clock level for four system clocks and changes the clock and the data only at falling edges of `clk`. It changes `ser_data` only on the line-clock edge that does not sample, so the data is steady through the synchronizer when it is sampled. It changes the configuration only inside a reset pulse.

// File: rtl/t1tx_pkg.sv
package t1tx_pkg;
  localparam int unsigned CH_BITS_DEF = 8;
  localparam int unsigned CH_COUNT_DEF = 24;

  typedef struct packed {
    logic rise;
    logic fall;
  } lclk_edges_t;

  function automatic int unsigned frame_len(input int unsigned bits, input int unsigned chans);
    return bits * chans + 1;
  endfunction
endpackage

// File: rtl/t1tx_edge_sync.sv
module t1tx_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lclk_in,
  input  logic                  data_in,
  output t1tx_pkg::lclk_edges_t edges,
  output logic                  data_s
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] lsync;
  logic [SYNC_STAGES-1:0] dsync;
  logic                   lprev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          lsync <= '0;
          dsync <= '0;
        end else begin
          lsync <= lclk_in;
          dsync <= data_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          lsync <= '0;
          dsync <= '0;
        end else begin
          lsync <= {lsync[SYNC_STAGES-2:0], lclk_in};
          dsync <= {dsync[SYNC_STAGES-2:0], data_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lprev <= 1'b0;
    else     lprev <= lsync[LAST];
  end

  always_comb begin
    edges.rise = lsync[LAST] & ~lprev;
    edges.fall = ~lsync[LAST] & lprev;
    data_s     = dsync[LAST];
  end

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(edges.rise && edges.fall)); // R2
  AST_RISE_THEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    edges.rise |=> !edges.rise && !edges.fall); // R2
endmodule

// File: rtl/t1tx_slot_counter.sv
module t1tx_slot_counter #(
  parameter int unsigned CH_BITS  = 8,
  parameter int unsigned CH_COUNT = 24
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        adv,
  output logic                        fslot,
  output logic                        fslot_nxt,
  output logic [$clog2(CH_BITS)-1:0]  bit_pos,
  output logic [$clog2(CH_COUNT)-1:0] chan_idx,
  output logic                        last_bit
);
  localparam int unsigned BIT_W = $clog2(CH_BITS);
  localparam int unsigned CH_W  = $clog2(CH_COUNT);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CH_BITS - 1);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(CH_COUNT - 1);

  logic             fslot_d;
  logic [BIT_W-1:0] bit_d;
  logic [CH_W-1:0]  ch_d;

  assign last_bit = !fslot && (bit_pos == BIT_LAST);

  always_comb begin
    fslot_d = fslot;
    bit_d   = bit_pos;
    ch_d    = chan_idx;
    if (adv) begin
      if (fslot) begin
        fslot_d = 1'b0;
        bit_d   = '0;
        ch_d    = '0;
      end else if (bit_pos == BIT_LAST) begin
        bit_d = '0;
        if (chan_idx == CH_LAST) begin
          fslot_d = 1'b1;
          ch_d    = '0;
        end else begin
          ch_d = chan_idx + CH_W'(1);
        end
      end else begin
        bit_d = bit_pos + BIT_W'(1);
      end
    end
  end

  assign fslot_nxt = fslot_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      fslot    <= 1'b1;
      bit_pos  <= '0;
      chan_idx <= '0;
    end else begin
      fslot    <= fslot_d;
      bit_pos  <= bit_d;
      chan_idx <= ch_d;
    end
  end

  AST_FBIT_LEADS_CH1: assert property (@(posedge clk) disable iff (rst)
    adv && fslot |=> !fslot && bit_pos == '0 && chan_idx == '0); // R5
  AST_LAST_CH_WRAPS: assert property (@(posedge clk) disable iff (rst)
    adv && last_bit && chan_idx == CH_LAST |=> fslot); // R5
  AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    chan_idx <= CH_LAST); // R5
endmodule

// File: rtl/t1tx_byte_assembler.sv
module t1tx_byte_assembler #(
  parameter int unsigned CH_BITS  = 8,
  parameter int unsigned CH_COUNT = 24
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                adv,
  input  logic                                din,
  input  logic                                fslot,
  input  logic                                last_bit,
  input  logic [$clog2(CH_COUNT)-1:0]         chan_idx,
  output logic [CH_BITS-1:0]                  byte_data,
  output logic [$clog2(CH_COUNT+1)-1:0]       byte_chan,
  output logic                                byte_valid,
  output logic                                fbit_val,
  output logic                                fbit_valid
);
  localparam int unsigned CHAN_W = $clog2(CH_COUNT + 1);

  logic [CH_BITS-2:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      byte_data  <= '0;
      byte_chan  <= '0;
      byte_valid <= 1'b0;
      fbit_val   <= 1'b0;
      fbit_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      fbit_valid <= 1'b0;
      if (adv) begin
        if (fslot) begin
          fbit_val   <= din;
          fbit_valid <= 1'b1;
        end else begin
          shreg <= {shreg[CH_BITS-3:0], din};
          if (last_bit) begin
            byte_data  <= {shreg, din};
            byte_chan  <= CHAN_W'(chan_idx) + CHAN_W'(1);
            byte_valid <= 1'b1;
          end
        end
      end
    end
  end

  AST_CHAN_NUMBERED: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> (byte_chan >= CHAN_W'(1)) && (byte_chan <= CHAN_W'(CH_COUNT))); // R6
  AST_BYTE_STROBE_SHORT: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid); // R6
  AST_FBIT_STROBE_SHORT: assert property (@(posedge clk) disable iff (rst)
    fbit_valid |=> !fbit_valid); // R7
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    !(byte_valid && fbit_valid)); // R7
endmodule

// File: rtl/t1tx_pulse_gen.sv
module t1tx_pulse_gen (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic fslot_next,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst)      pulse <= 1'b0;
    else if (upd) pulse <= fslot_next;
  end
endmodule

// File: rtl/t1tx_sys_port.sv
module t1tx_sys_port #(
  parameter int unsigned CH_BITS     = t1tx_pkg::CH_BITS_DEF,
  parameter int unsigned CH_COUNT    = t1tx_pkg::CH_COUNT_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            line_clk,
  input  logic                            ser_data,
  input  logic                            smp_fall,
  input  logic                            pulse_rise,
  output logic                            frame_pulse,
  output logic [CH_BITS-1:0]              byte_data,
  output logic [$clog2(CH_COUNT+1)-1:0]   byte_chan,
  output logic                            byte_valid,
  output logic                            fbit_val,
  output logic                            fbit_valid
);
  localparam int unsigned BIT_W = $clog2(CH_BITS);
  localparam int unsigned CH_W  = $clog2(CH_COUNT);

  t1tx_pkg::lclk_edges_t edges;
  logic             data_s;
  logic             samp_edge;
  logic             pulse_edge;
  logic             fslot;
  logic             fslot_nxt;
  logic [BIT_W-1:0] bit_pos;
  logic [CH_W-1:0]  chan_idx;
  logic             last_bit;

  t1tx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .lclk_in (line_clk),
    .data_in (ser_data),
    .edges   (edges),
    .data_s  (data_s)
  );

  assign samp_edge  = smp_fall   ? edges.fall : edges.rise;
  assign pulse_edge = pulse_rise ? edges.rise : edges.fall;

  t1tx_slot_counter #(.CH_BITS(CH_BITS), .CH_COUNT(CH_COUNT)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .adv       (samp_edge),
    .fslot     (fslot),
    .fslot_nxt (fslot_nxt),
    .bit_pos   (bit_pos),
    .chan_idx  (chan_idx),
    .last_bit  (last_bit)
  );

  t1tx_byte_assembler #(.CH_BITS(CH_BITS), .CH_COUNT(CH_COUNT)) u_asm (
    .clk        (clk),
    .rst        (rst),
    .adv        (samp_edge),
    .din        (data_s),
    .fslot      (fslot),
    .last_bit   (last_bit),
    .chan_idx   (chan_idx),
    .byte_data  (byte_data),
    .byte_chan  (byte_chan),
    .byte_valid (byte_valid),
    .fbit_val   (fbit_val),
    .fbit_valid (fbit_valid)
  );

  t1tx_pulse_gen u_pulse (
    .clk        (clk),
    .rst        (rst),
    .upd        (pulse_edge),
    .fslot_next (fslot_nxt),
    .pulse      (frame_pulse)
  );

  AST_PULSE_ON_SEL_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(frame_pulse) |-> $past(pulse_edge)); // R3
  AST_OUT_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (byte_valid || fbit_valid) |-> $past(samp_edge)); // R2
  AST_PULSE_CLEAR_AFTER_FBIT: assert property (@(posedge clk) disable iff (rst)
    fbit_valid |-> !fslot); // R5
endmodule

// File: tb/tb_t1tx_sys_port.sv
module tb_t1tx_sys_port;
  localparam int CLK_P  = 10;
  localparam int FRAME  = 193;
  localparam int HALVES = 2 * FRAME * 2 + 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_clk = 1'b0;
  logic ser_data = 1'b0;
  logic smp_fall = 1'b0;
  logic pulse_rise = 1'b0;
  logic       frame_pulse;
  logic [7:0] byte_data;
  logic [4:0] byte_chan;
  logic       byte_valid;
  logic       fbit_val;
  logic       fbit_valid;

  int errors = 0;
  int checks = 0;
  int nsamp;
  int seed;
  int exp_sr;
  logic exp_pulse;
  logic exp_bv, exp_fv, exp_fbit;
  logic [7:0] exp_byte;
  int exp_chan;

  always #(CLK_P/2) clk = ~clk;

  t1tx_sys_port dut (
    .clk(clk), .rst(rst), .line_clk(line_clk), .ser_data(ser_data),
    .smp_fall(smp_fall), .pulse_rise(pulse_rise), .frame_pulse(frame_pulse),
    .byte_data(byte_data), .byte_chan(byte_chan), .byte_valid(byte_valid),
    .fbit_val(fbit_val), .fbit_valid(fbit_valid)
  );

  function automatic logic bitv(input int n, input int s);
    return logic'((((n * 13 + s) % 5) < 2) ^ ((n / FRAME) % 2 == 1));
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic check_idle(input string tag);
    chk(frame_pulse == exp_pulse, {tag, " pulse R4"}, frame_pulse, exp_pulse);
    chk(byte_valid == 1'b0, {tag, " byte strobe R6"}, byte_valid, 0);
    chk(fbit_valid == 1'b0, {tag, " fbit strobe R7"}, fbit_valid, 0);
  endtask

  task automatic half_period();
    logic rising, is_samp, is_pul;
    line_clk = ~line_clk;
    rising  = line_clk;
    is_samp = smp_fall ? !rising : rising;
    is_pul  = pulse_rise ? rising : !rising;
    exp_bv = 1'b0;
    exp_fv = 1'b0;
    if (is_samp) begin
      int idx;
      idx = nsamp % FRAME;
      if (idx == 0) begin
        exp_fv   = 1'b1;
        exp_fbit = bitv(nsamp, seed);
      end else begin
        exp_sr = ((exp_sr << 1) | int'(bitv(nsamp, seed))) & 8'hFF;
        if ((idx - 1) % 8 == 7) begin
          exp_bv   = 1'b1;
          exp_byte = 8'(exp_sr);
          exp_chan = (idx - 1) / 8 + 1;
        end
      end
      nsamp++;
    end else begin
      ser_data = bitv(nsamp, seed);
    end
    // R8: nothing visible before the third clock edge
    @(negedge clk); check_idle("R8 early");
    @(negedge clk); check_idle("R8 early");
    @(negedge clk);
    if (is_pul) exp_pulse = (nsamp % FRAME == 0);
    chk(frame_pulse == exp_pulse, "R3 R4 frame pulse", frame_pulse, exp_pulse);
    chk(byte_valid == exp_bv, "R2 R5 R6 byte_valid", byte_valid, exp_bv);
    chk(fbit_valid == exp_fv, "R5 R7 fbit_valid", fbit_valid, exp_fv);
    if (exp_bv) begin
      chk(byte_data == exp_byte, "R6 byte_data MSB first", byte_data, exp_byte);
      chk(int'(byte_chan) == exp_chan, "R6 byte_chan", byte_chan, exp_chan);
    end
    if (exp_fv) chk(fbit_val == exp_fbit, "R7 fbit_val", fbit_val, exp_fbit);
    @(negedge clk);
  endtask

  task automatic run_cfg(input logic sf, input logic pr, input int s);
    @(negedge clk);
    rst = 1'b1;
    line_clk = 1'b0;
    smp_fall = sf;
    pulse_rise = pr;
    seed = s;
    nsamp = 0;
    exp_sr = 0;
    exp_pulse = 1'b0;
    ser_data = bitv(0, s);
    repeat (4) @(negedge clk);
    check_idle("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");
    for (int h = 0; h < HALVES; h++) half_period();
  endtask

  initial begin
    run_cfg(1'b0, 1'b0, 3);   // R9-like: rising sample, falling pulse
    run_cfg(1'b1, 1'b1, 7);   // falling sample, rising pulse
    run_cfg(1'b1, 1'b0, 11);  // both on falling edge
    run_cfg(1'b0, 1'b1, 2);   // both on rising edge
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule